// File: doc/BRIEF.md
# Video Word Staging and Pixel Serializer

This block turns 16-bit video words, fetched from shared memory by a DMA channel, into a one-bit-per-pixel stream for a bilevel raster display. Each fetched word is first held in a staging register. A parallel-in serial-out shift register takes its next word from that staging register at the moment its current word runs out. A fetch request goes out as soon as the staging register has been emptied, so the following word is usually already waiting when it is needed. Address generation and memory arbitration belong to the DMA channel and sit outside this block.

A timing generator drives the block with a pixel clock enable, a blanking level and a line-start pulse. The line-start pulse arrives during horizontal blanking. It starts a prefetch of the line's first word and a preload of the shift register, so the first active pixel comes out with no bubble. Blanking masks the output through a delayed copy of the blank level that lines up with the serializer's own register stage. Because of that alignment, the final word of a line is shifted out in full before the output goes dark. If a word has not arrived by the time it must be loaded, the block shows black in its place and raises a sticky underrun flag.

Top module: `vser_top`

## Requirements
- R1: While reset is held and right after it is released, `pixOut`, `fetchReq` and `underrun` are all 0.
- R2: A pixel slot (`pixEn`=1) with `lineStart`=1 raises `fetchReq` on the next edge. The returned word is preloaded during blanking, so the first active slot of the line emits bit 15 of the line's first word.
- R3: Each active slot (`pixEn`=1, `blankIn`=0) emits one bit, most significant bit first. The bit appears on `pixOut` after that slot's clock edge.
- R4: After the slot that emits bit 0 of a word, the next active slot emits bit 15 of the next fetched word. A line is 36 words, which is 576 continuous pixels.
- R5: Exactly 36 rising edges of `fetchReq` occur between one `lineStart` and the end of that line. With no `lineStart` (vertical blanking) there are none.
- R6: `fetchReq` stays high until a cycle with `dmaValid`=1, which captures `dmaData` and clears the request. A `dmaValid` pulse while `fetchReq` is 0 changes nothing that is shown.
- R7: After a blanked slot `pixOut` is 0. The bit emitted in the last active slot of a line is still shown even when `blankIn` rises in the very next slot.
- R8: A word that is not in the staging register when it must be loaded shows as 16 black pixels and sets `underrun`. `underrun` stays set until the next `lineStart` slot clears it.
- R9: In a cycle with `pixEn`=0, `pixOut` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel clock enable; one pixel slot per high cycle |
| lineStart | input | 1 | Start of a displayed line; sampled with pixEn during blanking |
| blankIn | input | 1 | Current pixel slot is blanked |
| dmaValid | input | 1 | DMA delivers the requested word this cycle |
| dmaData | input | 16 | Video word from the DMA channel |
| fetchReq | output | 1 | Request for the next video word; held until dmaValid |
| pixOut | output | 1 | Serialized bilevel pixel |
| underrun | output | 1 | Sticky flag: a word was missing at load time this line |

## Verification
A wrong bit counter or reload point shows up at once: a whole word of the line is shifted in time or in content, starting at the first word boundary, which is no more than 16 active slots into the line. Bad staging-register bookkeeping leaves the fetch-request count per line different from 36, or lets a stray DMA pulse change a later word. Either shows within one line. A misaligned blank delay blacks out the last pixel of the line, or lets a pixel leak into blanking, on the first line boundary.

// File: rtl/vser_pkg.sv
package vser_pkg;

  // Strobes from the sequencing logic to the datapath.
  typedef struct packed {
    logic capture;  // write dmaData into the staging register
    logic load;     // copy staging register into the shift register
    logic clear;    // fill shift register with black
    logic shift;    // advance the shift register by one pixel
    logic step;     // pixel slot: update the output stage
  } serStrobe_t;

endpackage

// File: rtl/vser_ctrl.sv
module vser_ctrl
  import vser_pkg::*;
#(
  parameter int WORD_W = 16,   // must be a power of two
  parameter int WORDS  = 36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pixEn,
  input  logic       lineStart,
  input  logic       blankIn,
  input  logic       dmaValid,
  output serStrobe_t strb,
  output logic       fetchReq,
  output logic       underrun
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam int CNT_W = $clog2(WORDS + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] WORDS_C  = CNT_W'(WORDS);

  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] loadCnt;   // word slots of this line already started
  logic [CNT_W-1:0] fetchCnt;  // requests issued for this line
  logic stageFull;
  logic preloadPend;

  logic lsEv, shiftEv, capture, boundary, startMiss, preloadEv;
  logic wordsLeft, reloadOk, reloadMiss, endLine, loadEv, raiseFetch;

  always_comb begin
    lsEv       = pixEn & lineStart;
    shiftEv    = pixEn & ~blankIn & ~lineStart;
    capture    = dmaValid & fetchReq;
    startMiss  = shiftEv & preloadPend;
    boundary   = shiftEv & ~preloadPend & (bitCnt == LAST_BIT);
    preloadEv  = pixEn & blankIn & ~lineStart & preloadPend & stageFull;
    wordsLeft  = loadCnt < WORDS_C;
    reloadOk   = boundary & wordsLeft & stageFull;
    reloadMiss = boundary & wordsLeft & ~stageFull;
    endLine    = boundary & ~wordsLeft;
    loadEv     = preloadEv | reloadOk;
    raiseFetch = loadEv & (fetchCnt < WORDS_C);

    strb.capture = capture;
    strb.load    = loadEv;
    strb.clear   = lsEv | reloadMiss | endLine;
    strb.shift   = shiftEv;
    strb.step    = pixEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitCnt      <= '0;
      loadCnt     <= '0;
      fetchCnt    <= '0;
      stageFull   <= 1'b0;
      preloadPend <= 1'b0;
      fetchReq    <= 1'b0;
      underrun    <= 1'b0;
    end else if (lsEv) begin
      bitCnt      <= '0;
      loadCnt     <= '0;
      fetchCnt    <= CNT_W'(1);
      stageFull   <= 1'b0;
      preloadPend <= 1'b1;
      fetchReq    <= 1'b1;
      underrun    <= 1'b0;
    end else begin
      if (capture)     stageFull <= 1'b1;
      else if (loadEv) stageFull <= 1'b0;

      if (capture)         fetchReq <= 1'b0;
      else if (raiseFetch) fetchReq <= 1'b1;

      if (raiseFetch) fetchCnt <= fetchCnt + CNT_W'(1);

      if (preloadEv | startMiss) begin
        preloadPend <= 1'b0;
        loadCnt     <= CNT_W'(1);
      end else if (boundary & wordsLeft) begin
        loadCnt <= loadCnt + CNT_W'(1);
      end

      if (shiftEv) bitCnt <= bitCnt + BIT_W'(1);

      if (startMiss | reloadMiss) underrun <= 1'b1;
    end
  end

  // R2: a line start always issues the prefetch
  a_r2_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    (pixEn && lineStart) |=> fetchReq);

  // R6: an outstanding request is held until data comes back
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchReq && !dmaValid) |=> fetchReq);

  // R6: delivered data retires the request
  a_r6_req_done: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchReq && dmaValid && !(pixEn && lineStart)) |=> !fetchReq);

  // R8: the underrun flag is sticky within a line
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !(pixEn && lineStart)) |=> underrun);

endmodule

// File: rtl/vser_datapath.sv
module vser_datapath
  import vser_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  serStrobe_t        strb,
  input  logic              blankIn,
  input  logic [WORD_W-1:0] dmaData,
  output logic              pixOut
);

  logic [WORD_W-1:0] stageWord;
  logic [WORD_W-1:0] shiftWord;
  logic pixBit;
  logic blankDly;  // blank level aligned with pixBit

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stageWord <= '0;
      shiftWord <= '0;
      pixBit    <= 1'b0;
      blankDly  <= 1'b1;
    end else begin
      if (strb.capture) stageWord <= dmaData;

      if (strb.load)       shiftWord <= stageWord;
      else if (strb.clear) shiftWord <= '0;
      else if (strb.shift) shiftWord <= {shiftWord[WORD_W-2:0], 1'b0};

      if (strb.step) begin
        pixBit   <= shiftWord[WORD_W-1];
        blankDly <= blankIn;
      end
    end
  end

  assign pixOut = pixBit & ~blankDly;

  // R9: output only moves on pixel slots
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.step |=> $stable(pixOut));

  // R7: a blanked slot shows black
  a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && blankIn) |=> !pixOut);

endmodule

// File: rtl/vser_top.sv
module vser_top
  import vser_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pixEn,
  input  logic              lineStart,
  input  logic              blankIn,
  input  logic              dmaValid,
  input  logic [WORD_W-1:0] dmaData,
  output logic              fetchReq,
  output logic              pixOut,
  output logic              underrun
);

  serStrobe_t strb;

  vser_ctrl #(.WORD_W(WORD_W), .WORDS(WORDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pixEn     (pixEn),
    .lineStart (lineStart),
    .blankIn   (blankIn),
    .dmaValid  (dmaValid),
    .strb      (strb),
    .fetchReq  (fetchReq),
    .underrun  (underrun)
  );

  vser_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .blankIn (blankIn),
    .dmaData (dmaData),
    .pixOut  (pixOut)
  );

endmodule

// File: tb/test_vser_top.sv
module test_vser_top;

  localparam int WORDS = 36;
  localparam int LINE_PIX = WORDS * 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pixEn = 1'b0, lineStart = 1'b0, blankIn = 1'b1, dmaValid = 1'b0;
  logic [15:0] dmaData = '0;
  logic fetchReq, pixOut, underrun;

  int errors = 0, checks = 0;
  int serial = 0, dmaDelay = 0, cnt = 0, fetchRises = 0;
  bit busy = 0, prevReq = 0, inject = 0;

  always #4 clk = ~clk;

  vser_top i_vser_top (
    .clk(clk), .rst_n(rst_n), .pixEn(pixEn), .lineStart(lineStart),
    .blankIn(blankIn), .dmaValid(dmaValid), .dmaData(dmaData),
    .fetchReq(fetchReq), .pixOut(pixOut), .underrun(underrun)
  );

  function automatic logic [15:0] wordVal(int n);
    return 16'(n * 40503 + 4660) ^ 16'(n << 7);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: DMA model, fetch-edge counter, input drive, wait for negedge.
  task automatic tick(logic pe, logic bl, logic ls);
    dmaValid = 1'b0;
    if (busy) begin
      if (cnt == 0) begin
        dmaValid = 1'b1; dmaData = wordVal(serial); serial++; busy = 0;
      end else cnt--;
    end else if (fetchReq) begin
      busy = 1; cnt = dmaDelay;
    end
    if (inject && !busy && !dmaValid && !fetchReq) begin
      dmaValid = 1'b1; dmaData = 16'hFFFF; inject = 0;
    end
    if (fetchReq && !prevReq) fetchRises++;
    prevReq = fetchReq;
    pixEn = pe; blankIn = bl; lineStart = ls;
    @(negedge clk);
  endtask

  // One pixel slot followed by one idle clock; returns the shown pixel.
  task automatic slot(logic bl, logic ls, output logic shown);
    logic held;
    tick(1'b1, bl, ls);
    shown = pixOut;
    tick(1'b0, 1'b1, 1'b0);
    held = pixOut;
    chk("R9", held, shown);
  endtask

  task automatic runLine(int delay, bit doInject);
    logic p;
    int base;
    dmaDelay = delay;
    fetchRises = 0;
    base = serial;
    slot(1'b1, 1'b1, p);
    for (int i = 0; i < 20; i++) begin
      slot(1'b1, 1'b0, p);
      chk("R7", p, 0);
    end
    for (int s = 0; s < LINE_PIX; s++) begin
      logic [15:0] w;
      if (doInject && s == 104) inject = 1;
      slot(1'b0, 1'b0, p);
      w = wordVal(base + s / 16);
      if (s == 0) chk("R2", p, w[15]);
      else if (s == LINE_PIX - 1) chk("R7", p, w[0]);
      else if (doInject && s >= 112 && s < 128) chk("R6", p, w[15 - s % 16]);
      else if (s % 16 == 0) chk("R4", p, w[15]);
      else chk("R3", p, w[15 - s % 16]);
    end
    for (int i = 0; i < 10; i++) begin
      slot(1'b1, 1'b0, p);
      chk("R7", p, 0);
    end
    chk("R5", fetchRises, WORDS);
    chk("R8", underrun, 0);
  endtask

  task automatic vblank(int n);
    logic p;
    fetchRises = 0;
    for (int i = 0; i < n; i++) begin
      slot(1'b1, 1'b0, p);
      chk("R7", p, 0);
    end
    chk("R5", fetchRises, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic p;
    repeat (3) @(negedge clk);
    chk("R1", pixOut, 0);
    chk("R1", fetchReq, 0);
    chk("R1", underrun, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", pixOut, 0);
    chk("R1", fetchReq, 0);
    chk("R1", underrun, 0);

    vblank(5);
    runLine(0, 0);
    runLine(3, 1);
    runLine(6, 0);
    vblank(8);

    // Underrun line: data arrives far too late for the first word.
    dmaDelay = 100;
    slot(1'b1, 1'b1, p);
    for (int i = 0; i < 20; i++) slot(1'b1, 1'b0, p);
    for (int s = 0; s < 16; s++) begin
      slot(1'b0, 1'b0, p);
      chk("R8", p, 0);
      chk("R8", underrun, 1);
    end
    for (int s = 16; s < LINE_PIX; s++) slot(1'b0, 1'b0, p);
    for (int i = 0; i < 10; i++) slot(1'b1, 1'b0, p);
    chk("R8", underrun, 1);
    slot(1'b1, 1'b1, p);
    chk("R8", underrun, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule